// File: doc/BRIEF.md
# Keyed-Control Watchdog Timer

This block is a watchdog timer for a system chip. Its register port runs on the bus clock. The count itself moves only on a slow timebase, which reaches the block as a one-cycle `tick` enable. Software picks a restart value and, if it wants, a power-of-two prescale. It keeps the watchdog from firing by writing a fresh value to the trigger register, which puts the counter back at the restart value. If software stops doing this, the counter runs past its all-ones value and the block raises a one-cycle reset request.

Writes to the control, load, trigger and key registers are posted. Each write is held in a shadow slot and takes effect only after a fixed number of slow ticks. While a write is in flight, its own bit in the pending-status register reads 1, so software knows when it may write that register again. The run state cannot be changed by a single stray store. A start or stop needs a pair of key words, written back to back to the key register.

Top module: `wdtKeyed`

## Requirements
- R1: After reset the timer is running. The control register (word address 1) and the load register (word address 2) read 0. The pending register (word address 5) reads 0. The count (word address 6) reads 0, and `rstReq` is low.
- R2: Word address 0 returns the revision code `REV` in bits 7:0 and zeros in all higher bits.
- R3: While the timer is running and the prescaler is off, each `tick` adds exactly 1 to the count. The count reads back at word address 6.
- R4: Control register bit 5 turns the prescaler on, and bits 4:2 hold the ratio N. With the prescaler on, the count advances once every 2^N ticks, measured from the last reload.
- R5: A write to a posted register sets its pending bit: bit 0 for control, bit 2 for load, bit 3 for trigger (word address 3) and bit 4 for key (word address 4). The bit clears on the second `tick` after the write. The new value becomes effective, and readable, at that same edge and not before.
- R6: A write to a posted register whose pending bit is set is ignored.
- R7: When a trigger write takes effect with a value different from the trigger register's current contents, the count is set to the load value. A trigger write with the same value leaves the count alone.
- R8: A key write of 0xBBBB followed directly by a key write of 0x4444 starts the timer.
- R9: A key write of 0xAAAA followed directly by a key write of 0x5555 stops the timer.
- R10: If any other key word comes between the two words of a pair, the pair is dropped and the run state does not change.
- R11: When a running count steps past all-ones, `rstReq` is high for exactly one clock, and the count becomes the load value.
- R12: While the timer is stopped, ticks change neither the count nor `rstReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle slow-timebase enable |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| rstReq | output | 1 | One-cycle reset request on overflow |

## Verification
The hardest case to reach is the overflow. From reset, a 32-bit counter would need billions of ticks to get there. The bench instead programs a load value just below all-ones and posts a trigger word to pull the counter up to it. Counting the remaining ticks then lands the step onto the wrap edge, where the single-cycle pulse and the reload to the load value are checked. The same set-up, done once the timer has been stopped with a key pair, shows that the wrap never happens while the timer is halted.

// File: rtl/wdtPkg.sv
package wdtPkg;

  localparam int RATIO_W = 3;

  localparam logic [2:0] ADDR_REV   = 3'd0;
  localparam logic [2:0] ADDR_CTRL  = 3'd1;
  localparam logic [2:0] ADDR_LOAD  = 3'd2;
  localparam logic [2:0] ADDR_TRIG  = 3'd3;
  localparam logic [2:0] ADDR_KEY   = 3'd4;
  localparam logic [2:0] ADDR_PEND  = 3'd5;
  localparam logic [2:0] ADDR_COUNT = 3'd6;

  localparam logic [31:0] KEY_RUN_A  = 32'h0000_BBBB;
  localparam logic [31:0] KEY_RUN_B  = 32'h0000_4444;
  localparam logic [31:0] KEY_HALT_A = 32'h0000_AAAA;
  localparam logic [31:0] KEY_HALT_B = 32'h0000_5555;

  // Posted slots, in a fixed order: control, load, trigger, key.
  localparam int SLOTS = 4;

  typedef enum logic [1:0] {KEY_IDLE, KEY_RUN1, KEY_HALT1} keyState_t;

  typedef struct packed {
    logic               run;
    logic               reload;
    logic               preEn;
    logic [RATIO_W-1:0] ratio;
  } wdtStrobes_t;

  function automatic logic [2:0] slotAddr(input int idx);
    case (idx)
      0: slotAddr = ADDR_CTRL;
      1: slotAddr = ADDR_LOAD;
      2: slotAddr = ADDR_TRIG;
      default: slotAddr = ADDR_KEY;
    endcase
  endfunction

  function automatic int slotBit(input int idx);
    case (idx)
      0: slotBit = 0;
      1: slotBit = 2;
      2: slotBit = 3;
      default: slotBit = 4;
    endcase
  endfunction

endpackage

// File: rtl/wdtCtrl.sv
module wdtCtrl
  import wdtPkg::*;
#(
  parameter int          CNT_W      = 32,
  parameter int          DATA_W     = 32,
  parameter int          POST_TICKS = 2,
  parameter logic [7:0]  REV        = 8'h31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  countVal,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  loadVal,
  output logic [4:0]        pendBits,
  output wdtStrobes_t       strb
);

  localparam int PC_W = $clog2(POST_TICKS + 1);

  logic [SLOTS-1:0]  busy;
  logic [SLOTS-1:0]  commit;
  logic [DATA_W-1:0] holdArr [SLOTS];

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : gSlot
      logic [PC_W-1:0]   left;
      logic [DATA_W-1:0] hold;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          left <= '0;
          hold <= '0;
        end else if (wrEn && addr == slotAddr(g) && left == '0) begin
          left <= PC_W'(POST_TICKS);
          hold <= wdata;
        end else if (tick && left != '0) begin
          left <= left - PC_W'(1);
        end
      end
      assign busy[g]    = (left != '0);
      assign commit[g]  = tick && (left == PC_W'(1));
      assign holdArr[g] = hold;
    end
  endgenerate

  always_comb begin
    pendBits = '0;
    for (int i = 0; i < SLOTS; i++) pendBits[slotBit(i)] = busy[i];
  end

  logic                preEn;
  logic [RATIO_W-1:0]  ratio;
  logic [DATA_W-1:0]   trigReg;
  logic                running;
  keyState_t           keyState;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preEn   <= 1'b0;
      ratio   <= '0;
      loadVal <= '0;
      trigReg <= '0;
    end else begin
      if (commit[0]) begin
        preEn <= holdArr[0][5];
        ratio <= holdArr[0][4:2];
      end
      if (commit[1]) loadVal <= holdArr[1][CNT_W-1:0];
      if (commit[2]) trigReg <= holdArr[2];
    end
  end

  // Key pair sequencer: only the very next key word can complete a pair.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b1;
      keyState <= KEY_IDLE;
    end else if (commit[3]) begin
      if (keyState == KEY_RUN1 && holdArr[3] == KEY_RUN_B) begin
        running  <= 1'b1;
        keyState <= KEY_IDLE;
      end else if (keyState == KEY_HALT1 && holdArr[3] == KEY_HALT_B) begin
        running  <= 1'b0;
        keyState <= KEY_IDLE;
      end else if (holdArr[3] == KEY_RUN_A) begin
        keyState <= KEY_RUN1;
      end else if (holdArr[3] == KEY_HALT_A) begin
        keyState <= KEY_HALT1;
      end else begin
        keyState <= KEY_IDLE;
      end
    end
  end

  always_comb begin
    strb.run    = running;
    strb.reload = commit[2] && (holdArr[2] != trigReg);
    strb.preEn  = preEn;
    strb.ratio  = ratio;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_REV:   rdata[7:0] = REV;
      ADDR_CTRL:  begin
        rdata[5]   = preEn;
        rdata[4:2] = ratio;
      end
      ADDR_LOAD:  rdata = DATA_W'(loadVal);
      ADDR_TRIG:  rdata = trigReg;
      ADDR_PEND:  rdata[4:0] = pendBits;
      ADDR_COUNT: rdata = DATA_W'(countVal);
      default:    rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdtDatapath.sv
module wdtDatapath
  import wdtPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  wdtStrobes_t       strb,
  input  logic [CNT_W-1:0]  loadVal,
  output logic [CNT_W-1:0]  countVal,
  output logic              rstReq
);

  localparam int PRE_W = (1 << RATIO_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLim;
  logic             step;
  logic             wrap;

  assign preLim = (PRE_W'(1) << strb.ratio) - PRE_W'(1);
  assign step   = strb.run && tick && (!strb.preEn || preCnt == preLim);
  assign wrap   = step && (countVal == '1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal <= '0;
      preCnt   <= '0;
      rstReq   <= 1'b0;
    end else begin
      rstReq <= 1'b0;
      if (strb.reload) begin
        countVal <= loadVal;
        preCnt   <= '0;
      end else if (strb.run && tick) begin
        preCnt <= (step || !strb.preEn) ? '0 : preCnt + PRE_W'(1);
        if (wrap) begin
          countVal <= loadVal;
          rstReq   <= 1'b1;
        end else if (step) begin
          countVal <= countVal + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/wdtKeyed.sv
module wdtKeyed
  import wdtPkg::*;
#(
  parameter int         CNT_W      = 32,
  parameter int         POST_TICKS = 2,
  parameter logic [7:0] REV        = 8'h31
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        wrEn,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        rstReq
);

  wdtStrobes_t      strb;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] countVal;
  logic [4:0]       pendBits;

  wdtCtrl #(
    .CNT_W(CNT_W), .DATA_W(32), .POST_TICKS(POST_TICKS), .REV(REV)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .countVal(countVal), .rdata(rdata),
    .loadVal(loadVal), .pendBits(pendBits), .strb(strb)
  );

  wdtDatapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .tick(tick), .strb(strb),
    .loadVal(loadVal), .countVal(countVal), .rstReq(rstReq)
  );

endmodule

// File: rtl/wdtKeyedChk.sv
module wdtKeyedChk
  import wdtPkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             wrEn,
  input logic [2:0]       addr,
  input logic             rstReq,
  input logic [CNT_W-1:0] countVal,
  input logic [CNT_W-1:0] loadVal,
  input logic [4:0]       pendBits,
  input wdtStrobes_t      strb
);

  // R11
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  // R11
  ovf_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |-> countVal == $past(loadVal));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && tick && !strb.preEn && !strb.reload && countVal != '1)
      |=> countVal == $past(countVal) + CNT_W'(1));

  // R12
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.reload) |=> ($stable(countVal) && !rstReq));

  // R5
  pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_LOAD && !pendBits[2]) |=> pendBits[2]);

  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendBits[2] && !tick) |=> (pendBits[2] && $stable(loadVal)));

endmodule

bind wdtKeyed wdtKeyedChk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
  .rstReq(rstReq), .countVal(countVal), .loadVal(loadVal),
  .pendBits(pendBits), .strb(strb)
);

// File: tb/wdtKeyed_tb_top.sv
module wdtKeyed_tb_top;
  import wdtPkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rstReq;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  bit finished = 1'b0;

  wdtKeyed dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rstReq(rstReq)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (rstReq) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic testReset();
    logic [31:0] v;
    rd(ADDR_PEND, v);  chk("R1 pend", v, 32'h0);
    rd(ADDR_CTRL, v);  chk("R1 ctrl", v, 32'h0);
    rd(ADDR_LOAD, v);  chk("R1 load", v, 32'h0);
    rd(ADDR_COUNT, v); chk("R1 count", v, 32'h0);
    chk("R1 rstReq", {31'h0, rstReq}, 32'h0);
    rd(ADDR_REV, v);   chk("R2 rev", v, 32'h31);
  endtask

  task automatic testCount();
    logic [31:0] v;
    tk(5);
    rd(ADDR_COUNT, v); chk("R3 count after 5 ticks", v, 32'd5);
  endtask

  task automatic testPosted();
    logic [31:0] v;
    wr(ADDR_LOAD, 32'd100);
    rd(ADDR_PEND, v); chk("R5 load pending bit2", v, 32'h4);
    rd(ADDR_LOAD, v); chk("R5 load old value", v, 32'd0);
    tk(1);
    rd(ADDR_PEND, v); chk("R5 still pending", v, 32'h4);
    tk(1);
    rd(ADDR_PEND, v); chk("R5 pending cleared", v, 32'h0);
    rd(ADDR_LOAD, v); chk("R5 load committed", v, 32'd100);
    wr(ADDR_CTRL, 32'h0);
    rd(ADDR_PEND, v); chk("R5 ctrl pending bit0", v, 32'h1);
    tk(2);
    wr(ADDR_TRIG, 32'h0);
    rd(ADDR_PEND, v); chk("R5 trig pending bit3", v, 32'h8);
    tk(2);
  endtask

  task automatic testIgnore();
    logic [31:0] v;
    wr(ADDR_LOAD, 32'd200);
    wr(ADDR_LOAD, 32'd300);
    tk(2);
    rd(ADDR_LOAD, v); chk("R6 second write dropped", v, 32'd200);
  endtask

  task automatic testTrigger();
    logic [31:0] v;
    wr(ADDR_TRIG, 32'd1);
    tk(2);
    rd(ADDR_COUNT, v); chk("R7 reload on new value", v, 32'd200);
    tk(3);
    wr(ADDR_TRIG, 32'd1);
    tk(2);
    rd(ADDR_COUNT, v); chk("R7 same value no reload", v, 32'd205);
  endtask

  task automatic testPrescale();
    logic [31:0] v;
    wr(ADDR_CTRL, 32'h28);
    tk(2);
    rd(ADDR_CTRL, v); chk("R4 ctrl readback", v, 32'h28);
    wr(ADDR_TRIG, 32'd2);
    tk(2);
    rd(ADDR_COUNT, v); chk("R4 reloaded", v, 32'd200);
    tk(3);
    rd(ADDR_COUNT, v); chk("R4 no step before 4 ticks", v, 32'd200);
    tk(1);
    rd(ADDR_COUNT, v); chk("R4 step on 4th tick", v, 32'd201);
    tk(4);
    rd(ADDR_COUNT, v); chk("R4 step on 8th tick", v, 32'd202);
    wr(ADDR_CTRL, 32'h0);
    tk(2);
  endtask

  task automatic testHalt();
    logic [31:0] v, c0;
    wr(ADDR_KEY, KEY_HALT_A);
    rd(ADDR_PEND, v); chk("R5 key pending bit4", v, 32'h10);
    tk(2);
    wr(ADDR_KEY, KEY_HALT_B);
    tk(2);
    rd(ADDR_COUNT, c0);
    tk(5);
    rd(ADDR_COUNT, v); chk("R9 halted count frozen", v, c0);
  endtask

  task automatic testKeys();
    logic [31:0] v, c0;
    rd(ADDR_COUNT, c0);
    wr(ADDR_KEY, KEY_RUN_A);  tk(2);
    wr(ADDR_KEY, 32'h1234);   tk(2);
    wr(ADDR_KEY, KEY_RUN_B);  tk(2);
    tk(3);
    rd(ADDR_COUNT, v); chk("R10 broken pair ignored", v, c0);
    wr(ADDR_KEY, KEY_RUN_A);  tk(2);
    wr(ADDR_KEY, KEY_RUN_B);  tk(2);
    rd(ADDR_COUNT, c0);
    tk(3);
    rd(ADDR_COUNT, v); chk("R8 running after pair", v, c0 + 32'd3);
  endtask

  task automatic testOverflow();
    logic [31:0] v;
    int p0;
    wr(ADDR_LOAD, 32'hFFFF_FFF0); tk(2);
    wr(ADDR_TRIG, 32'd3);         tk(2);
    rd(ADDR_COUNT, v); chk("R11 preloaded", v, 32'hFFFF_FFF0);
    p0 = pulses;
    tk(15);
    rd(ADDR_COUNT, v); chk("R11 at all-ones", v, 32'hFFFF_FFFF);
    chk("R11 no early pulse", 32'(pulses), 32'(p0));
    tk(1);
    repeat (3) @(negedge clk);
    chk("R11 exactly one pulse", 32'(pulses), 32'(p0 + 1));
    rd(ADDR_COUNT, v); chk("R11 count reloaded", v, 32'hFFFF_FFF0);
  endtask

  task automatic testStoppedWrap();
    logic [31:0] v, c0;
    int p0;
    wr(ADDR_TRIG, 32'd4); tk(2);
    wr(ADDR_KEY, KEY_HALT_A); tk(2);
    wr(ADDR_KEY, KEY_HALT_B); tk(2);
    rd(ADDR_COUNT, c0);
    p0 = pulses;
    tk(20);
    rd(ADDR_COUNT, v); chk("R12 count held", v, c0);
    chk("R12 no pulse when stopped", 32'(pulses), 32'(p0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testCount();
    testPosted();
    testIgnore();
    testTrigger();
    testPrescale();
    testHalt();
    testKeys();
    testOverflow();
    testStoppedWrap();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule